// File: doc/BRIEF.md
# I2C Serial Memory Target

This block is an I2C-compatible target that fronts a 2048-byte memory, split into 128 pages of 16 bytes. It watches the SCL and SDA lines and finds START and STOP conditions. It then decodes the first byte after each START, which carries a fixed type code, the upper three memory address bits and the transfer direction. If the type code matches, the block acknowledges. It then takes a low address byte and stores data on writes, or it streams stored bytes back on reads.

The 11-bit memory address is built from two parts. Bits 3..1 of the device byte supply the upper three bits, and the word address byte supplies the lower eight. Any device byte with the right type code is therefore accepted, and it also picks one 256-byte block. An internal counter remembers the location after the last byte accessed. A read that starts with no address phase begins at that counter.

The block runs on a fast system clock and samples the bus through synchronisers. The bus line is wired-AND outside the block, and the block only reports when it wants SDA pulled low.

Top module: `i2cmem_target`

## Requirements
- R1: A device byte whose bits 7..4 equal 4'b1010 is acknowledged. Any other value leaves SDA released in the ninth clock, and every later byte is ignored and left unacknowledged until the next START.
- R2: The write location is {device byte bits 3..1, word address byte}, where device byte bit 3 is A10 and the word address byte holds A7..A0.
- R3: Device byte bit 0 picks the direction: 0 means write, where a word address byte follows, and 1 means read, where the block sends data.
- R4: In a write, each data byte after the word address is acknowledged and stored at the current location.
- R5: During a write, the low 4 address bits step by one and wrap within the 16-byte page, and A10..A4 stay unchanged.
- R6: A random read is a write header with a word address, then a repeated START and a read device byte. It returns the byte stored at that address.
- R7: A read with no address phase starts at the internal counter, which holds the last accessed location plus one, whether that access was a read or a write.
- R8: During a read, data goes out MSB first, changing while SCL is low. A controller ACK moves on to the next byte, and the address rolls over from 2047 to 0.
- R9: A controller NACK after a read byte ends the transfer, and SDA stays released afterwards.
- R10: A repeated START at any point restarts device byte decoding, and a STOP returns the block to idle.
- R11: Reset releases SDA and sets the internal counter to 0. Memory contents are kept across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl | input | 1 | Serial clock line level |
| sda | input | 1 | Resolved serial data line level |
| sda_pull | output | 1 | High when the block pulls SDA low |

## Verification
The vector table writes single bytes to eight locations, one in each of the eight 256-byte blocks. It reads them back with random reads. A mix-up between the block bits and the word address byte shows up as crossed data.

The directed tests cover several distinct patterns:
- A four-byte page write that starts two bytes before the end of a page. It separates a correct in-page wrap from a carry into the next page.
- A sequential read that crosses address 2047. It shows rollover to zero.
- A wrong type code followed by data. It must leave location 0 untouched.
- Current-address reads after a write, after a read, after a repeated START and after reset. These tell apart each way the internal counter can be updated.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } phase_t;

    typedef enum logic [1:0] {
        K_DEV,
        K_WADDR,
        K_DATA
    } rx_kind_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic type_match(input logic [7:0] b);
        return b[7:4] == DEV_TYPE;
    endfunction

endpackage

// File: rtl/i2cmem_bus_watch.sv
module i2cmem_bus_watch
    import i2cmem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);

    logic [SYNC_STAGES-1:0] scl_s, sda_s;
    logic scl_q, sda_q, scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_s <= '1;
            sda_s <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_s[0] <= scl;
            sda_s[0] <= sda;
            scl_p    <= scl_q;
            sda_p    <= sda_q;
        end
    end

    generate
        for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_s[i] <= 1'b1;
                    sda_s[i] <= 1'b1;
                end else begin
                    scl_s[i] <= scl_s[i-1];
                    sda_s[i] <= sda_s[i-1];
                end
            end
        end
    endgenerate

    assign scl_q = scl_s[SYNC_STAGES-1];
    assign sda_q = sda_s[SYNC_STAGES-1];

    always_comb begin
        ev.start = scl_q & scl_p & sda_p & ~sda_q;
        ev.stop  = scl_q & scl_p & ~sda_p & sda_q;
        ev.rise  = scl_q & ~scl_p;
        ev.fall  = ~scl_q & scl_p;
        ev.sda   = sda_q;
    end

endmodule

// File: rtl/i2cmem_store.sv
module i2cmem_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/i2cmem_ctrl.sv
module i2cmem_ctrl
    import i2cmem_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              sda_pull
);

    localparam int HI_W  = ADDR_W - DATA_W;
    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam logic [BIT_W-1:0] BYTE_DONE = BIT_W'(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_W - 1);

    phase_t            phase;
    rx_kind_t          kind;
    logic [BIT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] shreg, txreg;
    logic [ADDR_W-1:0] addr_q;
    logic [HI_W-1:0]   hi_q;
    logic              rw_q, mack_q;
    logic              byte_end, tx_load;

    function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
        logic [PAGE_W-1:0] low;
        low = a[PAGE_W-1:0] + 1'b1;
        return {a[ADDR_W-1:PAGE_W], low};
    endfunction

    assign byte_end = (phase == ST_RX) && ev.fall && (bitcnt == BYTE_DONE);
    assign tx_load  = !ev.start && !ev.stop && ev.fall &&
                      (((phase == ST_ACK) && rw_q) || ((phase == ST_MACK) && mack_q));

    assign mem_we    = byte_end && (kind == K_DATA) && !rw_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = shreg;
    assign sda_pull  = (phase == ST_ACK) || ((phase == ST_TX) && !txreg[DATA_W-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= ST_IDLE;
            kind   <= K_DEV;
            bitcnt <= '0;
            shreg  <= '0;
            txreg  <= '0;
            addr_q <= '0;
            hi_q   <= '0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
        end else if (ev.start) begin
            phase  <= ST_RX;
            kind   <= K_DEV;
            bitcnt <= '0;
        end else if (ev.stop) begin
            phase  <= ST_IDLE;
        end else begin
            unique case (phase)
                ST_RX: begin
                    if (ev.rise && bitcnt != BYTE_DONE) begin
                        shreg  <= {shreg[DATA_W-2:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_end) begin
                        unique case (kind)
                            K_DEV: begin
                                if (type_match(shreg)) begin
                                    rw_q  <= shreg[0];
                                    hi_q  <= shreg[HI_W:1];
                                    kind  <= K_WADDR;
                                    phase <= ST_ACK;
                                end else begin
                                    phase <= ST_IDLE;
                                end
                            end
                            K_WADDR: begin
                                addr_q <= {hi_q, shreg};
                                kind   <= K_DATA;
                                phase  <= ST_ACK;
                            end
                            default: begin
                                addr_q <= page_next(addr_q);
                                phase  <= ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (ev.fall) begin
                        bitcnt <= '0;
                        phase  <= rw_q ? ST_TX : ST_RX;
                    end
                end
                ST_TX: begin
                    if (ev.fall) begin
                        if (bitcnt == LAST_BIT) begin
                            bitcnt <= '0;
                            phase  <= ST_MACK;
                        end else begin
                            txreg  <= {txreg[DATA_W-2:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.rise) mack_q <= ~ev.sda;
                    if (ev.fall) begin
                        phase <= mack_q ? ST_TX : ST_IDLE;
                    end
                end
                default: ;
            endcase
            if (tx_load) begin
                txreg  <= mem_rdata;
                addr_q <= addr_q + 1'b1;
            end
        end
    end

    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && !ev.start) |=> (phase == ST_IDLE));

    // R10
    start_decode_chk: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (phase == ST_RX && kind == K_DEV && bitcnt == '0));

    // R1
    type_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_end && kind == K_DEV && !type_match(shreg)) |=> (!sda_pull && phase == ST_IDLE));

    // R5
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W])));

    // R8
    read_advance_chk: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

    // R9
    nack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_MACK && ev.fall && !mack_q && !ev.start && !ev.stop) |=> !sda_pull);

endmodule

// File: rtl/i2cmem_target.sv
module i2cmem_target
    import i2cmem_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl,
    input  logic sda,
    output logic sda_pull
);

    bus_ev_t           ev;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    i2cmem_bus_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
        .clk (clk),
        .rst (rst),
        .scl (scl),
        .sda (sda),
        .ev  (ev)
    );

    i2cmem_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .sda_pull  (sda_pull)
    );

    i2cmem_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    // R11
    reset_release_chk: assert property (@(posedge clk)
        $past(rst) |-> !sda_pull);

endmodule

// File: tb/i2cmem_target_test.sv
module i2cmem_target_test;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_line;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    logic ack_seen;
    logic [7:0] rd;

    assign sda_line = sda_m & ~sda_pull;

    always #2 clk = ~clk;

    i2cmem_target uut (
        .clk      (clk),
        .rst      (rst),
        .scl      (scl),
        .sda      (sda_line),
        .sda_pull (sda_pull)
    );

    localparam logic [18:0] VEC [0:7] = '{
        {11'h000, 8'h5A}, {11'h123, 8'hA7}, {11'h2FF, 8'h0F}, {11'h3A5, 8'hC4},
        {11'h4C0, 8'h81}, {11'h5DE, 8'h3B}, {11'h6F1, 8'hE2}, {11'h7FF, 8'h6D}
    };

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl = 1'b1;   wq();
        sda_m = 1'b0; wq();
        scl = 1'b0;   wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl = 1'b1;   wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wq();
        scl = 1'b1; wq(); wq();
        scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda_m = 1'b1; wq();
        scl = 1'b1; wq();
        ack_seen = (sda_line == 1'b0);
        wq();
        scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl = 1'b1; wq();
            d[i] = sda_line;
            wq();
            scl = 1'b0; wq();
        end
        bit_out(~give_ack);
    endtask

    task automatic do_write(input logic [10:0] a, input logic [7:0] d);
        bus_start();
        send_byte({4'hA, a[10:8], 1'b0}); check("R3 write header ack", 16'(ack_seen), 16'h1);
        send_byte(a[7:0]);                check("R2 word address ack", 16'(ack_seen), 16'h1);
        send_byte(d);                     check("R4 data ack", 16'(ack_seen), 16'h1);
        bus_stop();
    endtask

    task automatic rand_read(input logic [10:0] a, output logic [7:0] d);
        bus_start();
        send_byte({4'hA, a[10:8], 1'b0});
        send_byte(a[7:0]);
        bus_start();
        send_byte({4'hA, a[10:8], 1'b1});
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic cur_read(output logic [7:0] d);
        bus_start();
        send_byte({4'hA, 3'b000, 1'b1});
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual %h expected %h", 1'b0, 1'b1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check("R11 sda released in reset", 16'(sda_pull), 16'h0);
        rst = 1'b0;
        wq();
        check("R11 sda released after reset", 16'(sda_pull), 16'h0);

        // R2 R4: one write per 256-byte block, then random reads (R6)
        for (int i = 0; i < 8; i++) do_write(VEC[i][18:8], VEC[i][7:0]);
        for (int i = 0; i < 8; i++) begin
            rand_read(VEC[i][18:8], rd);
            check("R6 R2 random read", 16'(rd), 16'(VEC[i][7:0]));
        end

        // R7: counter after a read
        do_write(11'h124, 8'hC3);
        rand_read(11'h123, rd);
        check("R6 read 0x123", 16'(rd), 16'hA7);
        cur_read(rd);
        check("R7 current read after read", 16'(rd), 16'hC3);

        // R7: counter after a write
        do_write(11'h301, 8'h99);
        do_write(11'h300, 8'h77);
        cur_read(rd);
        check("R7 current read after write", 16'(rd), 16'h99);

        // R5: page write wraps inside page
        do_write(11'h210, 8'hEE);
        bus_start();
        send_byte({4'hA, 3'b010, 1'b0});
        send_byte(8'h0E);
        for (int i = 0; i < 4; i++) begin
            send_byte(8'h10 + 8'(i));
            check("R4 page data ack", 16'(ack_seen), 16'h1);
        end
        bus_stop();
        rand_read(11'h20E, rd); check("R5 page byte0", 16'(rd), 16'h10);
        rand_read(11'h20F, rd); check("R5 page byte1", 16'(rd), 16'h11);
        rand_read(11'h200, rd); check("R5 wrapped byte2", 16'(rd), 16'h12);
        rand_read(11'h201, rd); check("R5 wrapped byte3", 16'(rd), 16'h13);
        rand_read(11'h210, rd); check("R5 next page untouched", 16'(rd), 16'hEE);

        // R8: sequential read across 2047 -> 0
        do_write(11'h7FE, 8'h31);
        bus_start();
        send_byte({4'hA, 3'b111, 1'b0});
        send_byte(8'hFE);
        bus_start();
        send_byte({4'hA, 3'b111, 1'b1});
        recv_byte(1'b1, rd); check("R8 seq byte 0x7FE", 16'(rd), 16'h31);
        recv_byte(1'b1, rd); check("R8 seq byte 0x7FF", 16'(rd), 16'h6D);
        recv_byte(1'b0, rd); check("R8 rollover to 0x000", 16'(rd), 16'h5A);
        wq();
        check("R9 sda released after nack", 16'(sda_pull), 16'h0);
        bus_stop();
        wq();
        check("R10 idle after stop", 16'(sda_pull), 16'h0);

        // R1: wrong type code rejected, later bytes ignored
        bus_start();
        send_byte(8'hB0); check("R1 wrong type nack", 16'(ack_seen), 16'h0);
        send_byte(8'h00); check("R1 ignored byte nack", 16'(ack_seen), 16'h0);
        send_byte(8'h55); check("R1 ignored data nack", 16'(ack_seen), 16'h0);
        bus_stop();
        rand_read(11'h000, rd);
        check("R1 memory untouched", 16'(rd), 16'h5A);

        // R10: repeated START in the middle of a write
        do_write(11'h151, 8'h66);
        bus_start();
        send_byte({4'hA, 3'b001, 1'b0});
        send_byte(8'h50);
        send_byte(8'h44);
        bus_start();
        send_byte({4'hA, 3'b000, 1'b1});
        check("R10 restart header ack", 16'(ack_seen), 16'h1);
        recv_byte(1'b0, rd);
        bus_stop();
        check("R10 R7 read after restart", 16'(rd), 16'h66);
        rand_read(11'h150, rd);
        check("R10 byte before restart stored", 16'(rd), 16'h44);

        // R11: reset clears the counter, memory kept
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 sda released in reset", 16'(sda_pull), 16'h0);
        rst = 1'b0;
        wq();
        cur_read(rd);
        check("R11 counter zero after reset", 16'(rd), 16'h5A);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule